// File: doc/BRIEF.md
# Two-Law Serial Clock Rate Generator

This block derives the serial clock of an SPI-style shifter from a faster module clock. A control word selects one of two division laws. The linear law divides by 2×(N+1) using an 8-bit count. The power-of-two law divides by 2^N using a 4-bit exponent. Along with the clock, the block issues one-cycle strobes in the module-clock domain. A strobe marks each edge that leaves the idle level (leading) and each edge that returns to it (trailing). A shift engine uses these strobes to launch and capture data without sampling the serial clock itself.

The serial clock runs only while `xfer_active` is high. When it is low, the half-period counter is cleared and the output sits at the idle level chosen by `idle_level`. The division setting is captured in the first cycle of an exchange. Changes to the control word during an exchange therefore cannot alter or glitch a running clock. The module clock must run at least twice as fast as the fastest serial clock, so no setting divides by less than two.

Top module: `sclk_rate_gen`

## Requirements
- R1: `clk_cfg` layout with default widths: bits [7:0] hold the linear count N, bits [11:8] hold the exponent E, and bit 12 set selects the linear law. Under the linear law each half period of `sclk` lasts N+1 module-clock cycles, giving a full period of 2×(N+1).
- R2: With bit 12 clear and E ≥ 1, each half period lasts 2^(E-1) module-clock cycles, giving a full period of 2^E.
- R3: With bit 12 clear and E = 0, the block behaves as E = 1 (divide by two), so `sclk` never toggles faster than every module-clock cycle.
- R4: Within an exchange, the high and low phases of `sclk` have equal length (50% duty).
- R5: `clk_cfg` is sampled on the first rising edge at which `xfer_active` is high. `sclk` holds the idle level at that edge and makes its first transition exactly H edges later, where H is the half-period length.
- R6: Each transition of `sclk` away from the idle level comes with `lead_stb` high for that one cycle. Each transition back to idle comes with `trail_stb` high for that one cycle. Neither strobe is high in any other cycle, and both are never high together.
- R7: One edge after `xfer_active` is seen low, `sclk` is at the idle level and both strobes are low. The phase counter restarts from zero at the next exchange.
- R8: While no exchange is active, `sclk` follows `idle_level` with one cycle of delay.
- R9: A change to `clk_cfg` during an exchange has no effect on the running `sclk`; the new setting applies from the next exchange start.
- R10: During reset, `sclk`, `lead_stb` and `trail_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_active | input | 1 | High while an exchange is in progress; enables `sclk` |
| idle_level | input | 1 | Level of `sclk` between exchanges (clock polarity) |
| clk_cfg | input | LIN_W+POW_W+1 (13) | Linear count, exponent and law select |
| sclk | output | 1 | Divided serial clock |
| lead_stb | output | 1 | One-cycle strobe with each edge leaving idle |
| trail_stb | output | 1 | One-cycle strobe with each edge returning to idle |

## Verification
The bench builds the block with its default widths: an 8-bit linear count and a 4-bit exponent. These widths make both extremes of each law reachable within the cycle budget: half periods of 1 and 256 cycles for the linear law, and of 1 through 16384 cycles for the power-of-two law. Every scenario tracks an expected clock and strobe pattern, cycle by cycle, from the start edge. Both idle levels are covered, as is a control word that is rewritten in mid-exchange.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  // Width of a half-period count able to hold both laws' largest value.
  function automatic int half_cnt_width(input int lin_w, input int pow_w);
    int lin_need;
    int pow_need;
    lin_need = lin_w + 1;
    pow_need = (1 << pow_w) - 1;
    if (pow_need < 1) pow_need = 1;
    return (lin_need > pow_need) ? lin_need : pow_need;
  endfunction

  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } sclk_edge_e;

endpackage

// File: rtl/sclk_div_decode.sv
module sclk_div_decode #(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  parameter int CNT_W = 15
) (
  input  logic             lin_sel,
  input  logic [LIN_W-1:0] lin_n,
  input  logic [POW_W-1:0] pow_n,
  output logic [CNT_W-1:0] half_len
);

  // Half-period length in module-clock cycles for either law.
  function automatic logic [CNT_W-1:0] calc_half(input logic sel,
                                                  input logic [LIN_W-1:0] n_lin,
                                                  input logic [POW_W-1:0] n_pow);
    if (sel)
      return CNT_W'(n_lin) + CNT_W'(1);
    else if (n_pow <= POW_W'(1))
      return CNT_W'(1);
    else
      return CNT_W'(1) << (n_pow - POW_W'(1));
  endfunction

  always_comb half_len = calc_half(lin_sel, lin_n, pow_n);

endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_active,
  input  logic [CNT_W-1:0] half_len,
  output logic             run,
  output logic             half_tick
);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hlen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      hlen_q <= CNT_W'(1);
    end else if (!xfer_active) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      hlen_q <= half_len;
    end else if (half_tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign run       = run_q;
  assign half_tick = run_q && (cnt_q == hlen_q - CNT_W'(1));

  // R7
  cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < hlen_q));

  // R9
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(hlen_q));

  // R7
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> (cnt_q == '0 && !run_q));

endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen
  import sclk_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_active,
  input  logic       idle_level,
  input  logic       half_tick,
  output logic       sclk,
  output sclk_edge_e edge_kind
);

  logic       sclk_q;
  logic       idle_q;
  sclk_edge_e edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      idle_q <= 1'b0;
      edge_q <= EDGE_NONE;
    end else if (!xfer_active) begin
      sclk_q <= idle_level;
      idle_q <= idle_level;
      edge_q <= EDGE_NONE;
    end else if (half_tick) begin
      sclk_q <= ~sclk_q;
      edge_q <= (sclk_q == idle_q) ? EDGE_LEAD : EDGE_TRAIL;
    end else begin
      edge_q <= EDGE_NONE;
    end
  end

  assign sclk      = sclk_q;
  assign edge_kind = edge_q;

  // R6
  strobe_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q != EDGE_NONE) |-> (sclk_q != $past(sclk_q)));

  // R6
  lead_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q == EDGE_LEAD) |-> (sclk_q != idle_q));

  // R6
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sclk_q != $past(sclk_q)) && $past(xfer_active)) |-> (edge_q != EDGE_NONE));

  // R7
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> (sclk_q == $past(idle_level) && edge_q == EDGE_NONE));

endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     xfer_active,
  input  logic                     idle_level,
  input  logic [LIN_W+POW_W:0]     clk_cfg,
  output logic                     sclk,
  output logic                     lead_stb,
  output logic                     trail_stb
);

  localparam int SEL_BIT = LIN_W + POW_W;
  localparam int CNT_W   = half_cnt_width(LIN_W, POW_W);

  logic [CNT_W-1:0] half_len;
  logic             run;
  logic             half_tick;
  sclk_edge_e       edge_kind;

  sclk_div_decode #(.LIN_W(LIN_W), .POW_W(POW_W), .CNT_W(CNT_W)) u_decode (
    .lin_sel  (clk_cfg[SEL_BIT]),
    .lin_n    (clk_cfg[LIN_W-1:0]),
    .pow_n    (clk_cfg[SEL_BIT-1:LIN_W]),
    .half_len (half_len)
  );

  sclk_half_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_active (xfer_active),
    .half_len    (half_len),
    .run         (run),
    .half_tick   (half_tick)
  );

  sclk_edge_gen u_edges (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_active (xfer_active),
    .idle_level  (idle_level),
    .half_tick   (half_tick),
    .sclk        (sclk),
    .edge_kind   (edge_kind)
  );

  assign lead_stb  = (edge_kind == EDGE_LEAD);
  assign trail_stb = (edge_kind == EDGE_TRAIL);

  // R5
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !run) |=> (!lead_stb && !trail_stb));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_stb, trail_stb}));

endmodule

// File: tb/test_sclk_rate_gen.sv
module test_sclk_rate_gen;

  localparam int LIN_W = 8;
  localparam int POW_W = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 xfer_active = 1'b0;
  logic                 idle_level = 1'b0;
  logic [LIN_W+POW_W:0] clk_cfg = '0;
  logic                 sclk;
  logic                 lead_stb;
  logic                 trail_stb;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sclk_rate_gen #(.LIN_W(LIN_W), .POW_W(POW_W)) i_sclk_rate_gen (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .idle_level(idle_level),
    .clk_cfg(clk_cfg), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  function automatic int exp_half(input bit sel, input int lin, input int pw);
    if (sel) return lin + 1;
    if (pw == 0) return 1;
    return (2 ** pw) / 2;
  endfunction

  function automatic logic [LIN_W+POW_W:0] pack(input bit sel, input int lin, input int pw);
    return {sel, POW_W'(pw), LIN_W'(lin)};
  endfunction

  task automatic check(input string tag, input bit ok, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One exchange: watch ntog transitions, then deactivate and check gating.
  task automatic run_case(input string tag, input bit sel, input int lin, input int pw,
                          input bit idle, input int ntog, input bit change_mid);
    int  h;
    int  bad_clk, bad_stb, first_bad;
    int  act_bad, exp_bad;
    int  toggles;
    bit  exp_sclk;
    h = exp_half(sel, lin, pw);
    @(negedge clk);
    idle_level  = idle;
    clk_cfg     = pack(sel, lin, pw);
    xfer_active = 1'b0;
    repeat (2) @(negedge clk);
    // R8: idle level visible while inactive
    check("R8", sclk == idle, {tag, " idle level"}, int'(sclk), int'(idle));
    xfer_active = 1'b1;
    exp_sclk  = idle;
    bad_clk   = 0;
    bad_stb   = 0;
    first_bad = -1;
    act_bad   = 0;
    exp_bad   = 0;
    toggles   = 0;
    for (int i = 1; i <= h * ntog + 1; i++) begin
      bit exp_tog;
      bit exp_lead;
      bit exp_trail;
      @(negedge clk);
      if (change_mid && i == 2) clk_cfg = pack(!sel, 0, 0);
      exp_tog   = (i >= h + 1) && (((i - 1) % h) == 0);
      if (exp_tog) begin
        exp_sclk = ~exp_sclk;
        toggles++;
      end
      exp_lead  = exp_tog && (exp_sclk != idle);
      exp_trail = exp_tog && (exp_sclk == idle);
      if (sclk != exp_sclk) begin
        if (first_bad < 0) begin
          first_bad = i; act_bad = int'(sclk); exp_bad = int'(exp_sclk);
        end
        bad_clk++;
      end
      if (lead_stb != exp_lead || trail_stb != exp_trail) bad_stb++;
    end
    // R1 R2 R3 R4 R5 R9: clock pattern against half period h
    check(tag, bad_clk == 0, $sformatf("sclk pattern h=%0d first_bad_cycle=%0d", h, first_bad),
          act_bad, exp_bad);
    // R6: strobe pattern
    check("R6", bad_stb == 0, {tag, " strobe mismatches"}, bad_stb, 0);
    check(tag, toggles == ntog, "toggle count", toggles, ntog);
    xfer_active = 1'b0;
    @(negedge clk);
    // R7: gated to idle one edge later
    check("R7", sclk == idle && !lead_stb && !trail_stb, {tag, " gate off"},
          int'({sclk, lead_stb, trail_stb}), int'({idle, 2'b00}));
    bad_clk = 0;
    repeat (6) begin
      @(negedge clk);
      if (sclk != idle || lead_stb || trail_stb) bad_clk++;
    end
    check("R7", bad_clk == 0, {tag, " stays idle"}, bad_clk, 0);
  endtask

  task automatic reset_case();
    @(negedge clk);
    // R10
    check("R10", sclk == 1'b0 && !lead_stb && !trail_stb, "reset outputs",
          int'({sclk, lead_stb, trail_stb}), 0);
  endtask

  task automatic idle_follow_case();
    @(negedge clk);
    xfer_active = 1'b0;
    idle_level  = 1'b1;
    @(negedge clk);
    check("R8", sclk == 1'b1, "follow idle high", int'(sclk), 1);
    idle_level = 1'b0;
    @(negedge clk);
    check("R8", sclk == 1'b0 && !lead_stb && !trail_stb, "follow idle low",
          int'({sclk, lead_stb, trail_stb}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_case();
    rst_n = 1'b1;
    run_case("R1", 1'b1, 0,   0, 1'b0, 6, 1'b0);
    run_case("R1", 1'b1, 3,   0, 1'b0, 5, 1'b0);
    run_case("R1", 1'b1, 255, 0, 1'b1, 3, 1'b0);
    run_case("R3", 1'b0, 0,   0, 1'b0, 6, 1'b0);
    run_case("R2", 1'b0, 0,   1, 1'b1, 6, 1'b0);
    run_case("R2", 1'b0, 0,   4, 1'b0, 5, 1'b0);
    run_case("R2", 1'b0, 0,  15, 1'b0, 2, 1'b0);
    run_case("R4", 1'b1, 6,   0, 1'b1, 8, 1'b0);
    run_case("R5", 1'b0, 0,   3, 1'b1, 1, 1'b0);
    run_case("R9", 1'b1, 9,   0, 1'b0, 4, 1'b1);
    run_case("R9", 1'b0, 0,   5, 1'b1, 3, 1'b1);
    idle_follow_case();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule